// File: doc/BRIEF.md
# Branch Resolve and Next-PC Unit

This unit settles control transfers for a 32-bit processor core. Each request carries the decoded transfer kind, the two register operands, the 4-bit immediate field, a displacement together with a flag that says whether the short or the long encoding was used, and the PC of the transfer instruction. One cycle after the unit accepts a request, it presents the following values:

- the address to fetch next;
- a link value and its write enable for the destination register;
- the static prediction that was read from the displacement;
- a flag that reports whether that prediction was wrong.

A wrong guess starts a stall counter. The counter raises `hold` for a fixed number of cycles so that the front end can refill.

Requests enter on a valid/ready handshake. `req_ready` equals `!hold`, so a mispredict holds off the next request until the refill window has ended. The result side has no back-pressure: `res_valid` is high for exactly one cycle for each accepted request, and the consumer must take the result in that cycle.

Top module: `brx_resolve_top`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. In the cycle after that edge `res_valid` is high and all result outputs are valid. In every other cycle `res_valid` is low. `req_ready` is always the inverse of `hold`.
- R2: The displacement target is the request PC plus the signed displacement, with the displacement's bit 0 cleared. In short form (`long_form`=0) only bits 15:0 of `disp` are used, sign-extended from bit 15.
- R3: The fall-through address is the PC plus 4 in short form and the PC plus 6 in long form.
- R4: Op 0 (jump) always goes to the displacement target. For op 0, `pred_taken` is 1 and `mispredict` is 0 whatever the value of `disp[0]`. `link_we` is 0.
- R5: For op 1 (conditional), `rx_val` is compared with a second operand as signed 32-bit numbers. The second operand is `ry_val` when `use_imm`=0, or the zero-extended `ry_field` when `use_imm`=1. The relation codes are: 0 equal, 1 less, 2 greater, 3 not equal, 4 less-or-equal, 5 greater-or-equal. If the relation holds, the transfer goes to the target; otherwise it falls through. `link_we` is 0.
- R6: For op 2 (loop), `link_val` is `rx_val` plus the zero-extended `ry_field` and `link_we` is 1. The transfer is taken exactly when that sum is negative.
- R7: For op 3 (call), the transfer goes to the displacement target. `link_val` is the fall-through address of R3, `link_we` is 1, `pred_taken` is 1 and `mispredict` is 0.
- R8: For op 4, the transfer goes to PC + `ry_val`. For op 5, it goes to `ry_val` exactly as given. Both ops write PC + 2 as the link with `link_we`=1, and both report `pred_taken`=0 and `mispredict`=0.
- R9: For ops 1 and 2, `pred_taken` equals `disp[0]`, and `mispredict` is high exactly when the resolved direction differs from `pred_taken`.
- R10: A mispredict raises `hold` in the same cycle as its result. `hold` then stays high for exactly 4 consecutive cycles and falls.
- R11: After reset, `res_valid`, `hold`, `link_we` and `mispredict` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (low during hold) |
| op | input | 3 | Transfer kind: 0 jump, 1 conditional, 2 loop, 3 call, 4 register-relative call, 5 absolute return |
| rel | input | 3 | Relation code for op 1 |
| use_imm | input | 1 | Compare against the 4-bit field instead of `ry_val` |
| ry_field | input | 4 | Raw 4-bit second-register field |
| rx_val | input | 32 | First register operand |
| ry_val | input | 32 | Second register operand |
| disp | input | 32 | Displacement; only bits 15:0 are used in short form |
| long_form | input | 1 | Long encoding (6-byte instruction) |
| pc | input | 32 | Address of the transfer instruction |
| res_valid | output | 1 | Result valid, one cycle per request |
| next_pc | output | 32 | Next fetch address |
| link_val | output | 32 | Value to write to the first register |
| link_we | output | 1 | Link write enable |
| pred_taken | output | 1 | Static prediction used by the front end |
| mispredict | output | 1 | Prediction disagreed with the outcome |
| hold | output | 1 | Refill stall in progress |

## Verification
The bench drives short-form displacements whose upper bits contradict bit 15. A design that forgot the sign extension would land far from the expected target. It also uses odd displacements, which catch a design that left the prediction bit in the address. Every relation code is run on both sides of its boundary, with negative register values against the immediate field. Swapped codes, unsigned compares or a sign-extended field then give the wrong direction. LOOP is run with sums of -1 and 0 so that an off-by-one in the sign test is seen, and jumps and calls carry a clear bit 0 so that a design that predicted them from the displacement would flag a mispredict. The length of every hold window is measured, and the bench checks that no request enters during a window. A design that stalls three or five cycles, or that accepts requests during the stall, is caught.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [2:0] {
    OP_JMP   = 3'd0,
    OP_BCOND = 3'd1,
    OP_LOOP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_CALLR = 3'd4,
    OP_RET   = 3'd5
  } brx_op_e;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_LT = 3'd1,
    REL_GT = 3'd2,
    REL_NE = 3'd3,
    REL_LE = 3'd4,
    REL_GE = 3'd5
  } brx_rel_e;
endpackage

// File: rtl/brx_cond_eval.sv
module brx_cond_eval #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   rel,
  output logic         hit
);
  import brx_pkg::*;

  logic eq, lt;
  assign eq = (a == b);
  assign lt = ($signed(a) < $signed(b));

  always_comb begin
    unique case (brx_rel_e'(rel))
      REL_EQ:  hit = eq;
      REL_LT:  hit = lt;
      REL_GT:  hit = !lt && !eq;
      REL_NE:  hit = !eq;
      REL_LE:  hit = lt || eq;
      REL_GE:  hit = !lt;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target_gen.sv
module brx_target_gen #(
  parameter int W       = 32,
  parameter int SHORT_W = 16,
  parameter int LEN_S   = 4,
  parameter int LEN_L   = 6,
  parameter int LEN_R   = 2
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] disp,
  input  logic         long_form,
  input  logic [W-1:0] ry_val,
  output logic [W-1:0] disp_tgt,
  output logic [W-1:0] seq_pc,
  output logic [W-1:0] rel_tgt,
  output logic [W-1:0] reg_link
);
  logic [W-1:0] short_ext, disp_sel;

  generate
    if (SHORT_W < W) begin : g_sext
      assign short_ext = {{(W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_full
      assign short_ext = disp;
    end
  endgenerate

  assign disp_sel = long_form ? disp : short_ext;
  assign disp_tgt = pc + {disp_sel[W-1:1], 1'b0};
  assign seq_pc   = pc + (long_form ? W'(LEN_L) : W'(LEN_S));
  assign rel_tgt  = pc + ry_val;
  assign reg_link = pc + W'(LEN_R);
endmodule

// File: rtl/brx_stall_ctr.sv
module brx_stall_ctr #(
  parameter int STALL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic hold
);
  localparam int CW = $clog2(STALL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(STALL);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);
endmodule

// File: rtl/brx_resolve_top.sv
module brx_resolve_top #(
  parameter int W       = 32,
  parameter int FLD_W   = 4,
  parameter int SHORT_W = 16,
  parameter int STALL   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       op,
  input  logic [2:0]       rel,
  input  logic             use_imm,
  input  logic [FLD_W-1:0] ry_field,
  input  logic [W-1:0]     rx_val,
  input  logic [W-1:0]     ry_val,
  input  logic [W-1:0]     disp,
  input  logic             long_form,
  input  logic [W-1:0]     pc,
  output logic             res_valid,
  output logic [W-1:0]     next_pc,
  output logic [W-1:0]     link_val,
  output logic             link_we,
  output logic             pred_taken,
  output logic             mispredict,
  output logic             hold
);
  import brx_pkg::*;

  logic [W-1:0] fld_ext, cmp_b, loop_sum;
  logic [W-1:0] disp_tgt, seq_pc, rel_tgt, reg_link;
  logic         cmp_hit, accept;
  logic [W-1:0] npc_c, link_c;
  logic         we_c, pred_c, mp_c, taken_c;

  assign fld_ext  = {{(W-FLD_W){1'b0}}, ry_field};
  assign cmp_b    = use_imm ? fld_ext : ry_val;
  assign loop_sum = rx_val + fld_ext;
  assign accept   = req_valid && req_ready;
  assign req_ready = !hold;

  brx_cond_eval #(.W(W)) u_cond (
    .a(rx_val), .b(cmp_b), .rel(rel), .hit(cmp_hit)
  );

  brx_target_gen #(.W(W), .SHORT_W(SHORT_W)) u_tgt (
    .pc(pc), .disp(disp), .long_form(long_form), .ry_val(ry_val),
    .disp_tgt(disp_tgt), .seq_pc(seq_pc), .rel_tgt(rel_tgt), .reg_link(reg_link)
  );

  always_comb begin
    npc_c   = seq_pc;
    link_c  = '0;
    we_c    = 1'b0;
    pred_c  = 1'b0;
    taken_c = 1'b0;
    mp_c    = 1'b0;
    unique case (brx_op_e'(op))
      OP_JMP: begin
        npc_c  = disp_tgt;
        pred_c = 1'b1;
      end
      OP_BCOND: begin
        taken_c = cmp_hit;
        pred_c  = disp[0];
        npc_c   = taken_c ? disp_tgt : seq_pc;
        mp_c    = taken_c ^ pred_c;
      end
      OP_LOOP: begin
        taken_c = loop_sum[W-1];
        pred_c  = disp[0];
        npc_c   = taken_c ? disp_tgt : seq_pc;
        mp_c    = taken_c ^ pred_c;
        link_c  = loop_sum;
        we_c    = 1'b1;
      end
      OP_CALL: begin
        npc_c  = disp_tgt;
        pred_c = 1'b1;
        link_c = seq_pc;
        we_c   = 1'b1;
      end
      OP_CALLR: begin
        npc_c  = rel_tgt;
        link_c = reg_link;
        we_c   = 1'b1;
      end
      OP_RET: begin
        npc_c  = ry_val;
        link_c = reg_link;
        we_c   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      next_pc    <= '0;
      link_val   <= '0;
      link_we    <= 1'b0;
      pred_taken <= 1'b0;
      mispredict <= 1'b0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        next_pc    <= npc_c;
        link_val   <= link_c;
        link_we    <= we_c;
        pred_taken <= pred_c;
        mispredict <= mp_c;
      end else begin
        link_we    <= 1'b0;
        mispredict <= 1'b0;
      end
    end
  end

  brx_stall_ctr #(.STALL(STALL)) u_stall (
    .clk(clk), .rst_n(rst_n), .load(accept && mp_c), .hold(hold)
  );
endmodule

// File: rtl/brx_resolve_chk.sv
module brx_resolve_chk #(
  parameter int STALL = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic res_valid,
  input logic link_we,
  input logic mispredict,
  input logic hold
);
  localparam int CW = $clog2(STALL + 2);
  logic [CW-1:0] hrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hrun <= '0;
    else if (hold) hrun <= hrun + 1'b1;
    else           hrun <= '0;
  end

  p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !res_valid);
  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !req_ready);
  p_link_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> res_valid);
  p_mp_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mispredict) |-> hold);
  p_hold_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (hrun < CW'(STALL)));
  p_hold_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (hrun == CW'(STALL)));
endmodule

bind brx_resolve_top brx_resolve_chk #(.STALL(STALL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .link_we(link_we), .mispredict(mispredict), .hold(hold)
);

// File: tb/brx_resolve_top_tb_top.sv
module brx_resolve_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  op = '0, rel = '0;
  logic        use_imm = 1'b0;
  logic [3:0]  ry_field = '0;
  logic [31:0] rx_val = '0, ry_val = '0, disp = '0, pc = '0;
  logic        long_form = 1'b0;
  logic        res_valid;
  logic [31:0] next_pc, link_val;
  logic        link_we, pred_taken, mispredict, hold;

  int checks = 0, errors = 0;
  int exp_holds = 0, seen_holds = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] npc;
    logic [31:0] link;
    logic        lwe;
    logic        pred;
    logic        mp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  brx_resolve_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op(op), .rel(rel), .use_imm(use_imm), .ry_field(ry_field),
    .rx_val(rx_val), .ry_val(ry_val), .disp(disp), .long_form(long_form),
    .pc(pc), .res_valid(res_valid), .next_pc(next_pc), .link_val(link_val),
    .link_we(link_we), .pred_taken(pred_taken), .mispredict(mispredict),
    .hold(hold)
  );

  function automatic exp_t model(input logic [2:0] o, input logic [2:0] r,
      input logic im, input logic [3:0] f, input logic [31:0] x,
      input logic [31:0] y, input logic [31:0] d, input logic lf,
      input logic [31:0] p);
    exp_t e;
    logic [31:0] sd, tgt, seq, b, s;
    logic hit;
    sd  = lf ? d : {{16{d[15]}}, d[15:0]};              // R2
    tgt = p + {sd[31:1], 1'b0};
    seq = p + (lf ? 32'd6 : 32'd4);                      // R3
    b   = im ? {28'd0, f} : y;
    case (r)
      3'd0: hit = (x == b);
      3'd1: hit = ($signed(x) <  $signed(b));
      3'd2: hit = ($signed(x) >  $signed(b));
      3'd3: hit = (x != b);
      3'd4: hit = ($signed(x) <= $signed(b));
      3'd5: hit = ($signed(x) >= $signed(b));
      default: hit = 1'b0;
    endcase
    e.npc = seq; e.link = 32'd0; e.lwe = 1'b0; e.pred = 1'b0; e.mp = 1'b0;
    case (o)
      3'd0: begin e.npc = tgt; e.pred = 1'b1; end
      3'd1: begin e.pred = d[0]; e.npc = hit ? tgt : seq; e.mp = hit ^ d[0]; end
      3'd2: begin
        s = x + {28'd0, f};
        e.link = s; e.lwe = 1'b1; e.pred = d[0];
        e.npc = s[31] ? tgt : seq; e.mp = s[31] ^ d[0];
      end
      3'd3: begin e.npc = tgt; e.pred = 1'b1; e.link = seq; e.lwe = 1'b1; end
      3'd4: begin e.npc = p + y; e.link = p + 32'd2; e.lwe = 1'b1; end
      3'd5: begin e.npc = y; e.link = p + 32'd2; e.lwe = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic issue(input string tag, input logic [2:0] o, input logic [2:0] r,
      input logic im, input logic [3:0] f, input logic [31:0] x,
      input logic [31:0] y, input logic [31:0] d, input logic lf,
      input logic [31:0] p);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    op = o; rel = r; use_imm = im; ry_field = f; rx_val = x; ry_val = y;
    disp = d; long_form = lf; pc = p; req_valid = 1'b1;
    e = model(o, r, im, f, x, y, d, lf, p);
    e.tag = tag;
    sb.push_back(e);
    if (e.mp) exp_holds++;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitor
  int hrun = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1: result with empty scoreboard, actual=1 expected=0");
        end else begin
          e = sb.pop_front();
          if (next_pc !== e.npc || link_val !== e.link || link_we !== e.lwe ||
              pred_taken !== e.pred || mispredict !== e.mp) begin
            errors++;
            $display("FAIL %s: actual npc=%h link=%h we=%b pred=%b mp=%b expected npc=%h link=%h we=%b pred=%b mp=%b",
              e.tag, next_pc, link_val, link_we, pred_taken, mispredict,
              e.npc, e.link, e.lwe, e.pred, e.mp);
          end
          checks++;
          if (hold !== e.mp) begin  // R10: hold rises with a mispredicted result
            errors++;
            $display("FAIL R10: hold at result actual=%b expected=%b", hold, e.mp);
          end
        end
      end
      if (hold) begin
        hrun++;
        if (req_ready) begin
          checks++; errors++;
          $display("FAIL R1: req_ready during hold actual=1 expected=0");
        end
      end else if (hrun != 0) begin
        checks++; seen_holds++;
        if (hrun != 4) begin
          errors++;
          $display("FAIL R10: hold length actual=%0d expected=4", hrun);
        end
        hrun = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R11
    if (res_valid !== 1'b0 || hold !== 1'b0 || link_we !== 1'b0 ||
        mispredict !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11: reset state actual=%b%b%b%b%b expected=00001",
        res_valid, hold, link_we, mispredict, req_ready);
    end
    rst_n = 1'b1;

    // R4 jump: short negative odd with junk upper bits, then even disp (no mispredict)
    issue("R4", 3'd0, 3'd0, 0, 4'd0, 0, 0, 32'hABCD_FFF1, 0, 32'h0000_1000);
    issue("R4", 3'd0, 3'd0, 0, 4'd0, 0, 0, 32'h0001_0000, 1, 32'h0000_2000);
    // R2 short sign extension, positive, junk upper half
    issue("R2", 3'd0, 3'd0, 0, 4'd0, 0, 0, 32'hFFFF_7FFE, 0, 32'h0000_0100);
    // R5 every relation, register operand, boundaries
    issue("R5", 3'd1, 3'd0, 0, 4'd0, 32'd7, 32'd7, 32'h0000_0041, 0, 32'h400);
    issue("R5", 3'd1, 3'd1, 0, 4'd0, 32'hFFFF_FFFF, 32'd0, 32'h0000_0040, 0, 32'h400);
    issue("R5", 3'd1, 3'd2, 0, 4'd0, 32'hFFFF_FFFF, 32'd0, 32'h0000_0041, 1, 32'h400);
    issue("R5", 3'd1, 3'd3, 0, 4'd0, 32'd5, 32'd5, 32'h0000_0040, 0, 32'h400);
    issue("R5", 3'd1, 3'd4, 0, 4'd0, 32'd5, 32'd5, 32'h0000_0021, 0, 32'h400);
    issue("R5", 3'd1, 3'd5, 0, 4'd0, 32'd4, 32'd5, 32'h0000_0020, 1, 32'h400);
    // R5 immediate field, negative rx and field 15 zero-extended
    issue("R5", 3'd1, 3'd1, 1, 4'hF, 32'hFFFF_FFF0, 32'd0, 32'h0000_FF81, 0, 32'h800);
    issue("R5", 3'd1, 3'd0, 1, 4'hF, 32'd15, 32'hFFFF_FFFF, 32'h0000_0080, 0, 32'h800);
    // R9 mispredict both ways
    issue("R9", 3'd1, 3'd0, 0, 4'd0, 32'd1, 32'd2, 32'h0000_0011, 0, 32'h900);
    issue("R9", 3'd1, 3'd0, 0, 4'd0, 32'd2, 32'd2, 32'h0000_0010, 1, 32'h900);
    // R6 loop: sum -1 (taken), sum 0 (fall through)
    issue("R6", 3'd2, 3'd0, 0, 4'd3, 32'hFFFF_FFFC, 0, 32'hFFFF_FFE1, 0, 32'hA00);
    issue("R6", 3'd2, 3'd0, 0, 4'd4, 32'hFFFF_FFFC, 0, 32'hFFFF_FFE0, 0, 32'hA00);
    issue("R6", 3'd2, 3'd0, 0, 4'd0, 32'h8000_0000, 0, 32'hFFFF_FFE0, 1, 32'hA00);
    // R7 call short and long, even disp
    issue("R7", 3'd3, 3'd0, 0, 4'd0, 0, 0, 32'h0000_0200, 0, 32'h3000);
    issue("R7", 3'd3, 3'd0, 0, 4'd0, 0, 0, 32'hFFF0_0000, 1, 32'h0100_0000);
    // R8 register-relative call and absolute return
    issue("R8", 3'd4, 3'd0, 0, 4'd0, 0, 32'hFFFF_FF00, 32'h0000_0001, 0, 32'h5000);
    issue("R8", 3'd5, 3'd0, 0, 4'd0, 0, 32'h0000_7777, 32'h0000_0001, 1, 32'h5000);
    // R1 back-to-back after a stall window
    issue("R1", 3'd1, 3'd3, 0, 4'd0, 32'd1, 32'd2, 32'h0000_0010, 0, 32'h6000);
    issue("R1", 3'd0, 3'd0, 0, 4'd0, 0, 0, 32'h0000_0004, 0, 32'h6000);

    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: pending results actual=%0d expected=0", sb.size());
    end
    checks++;
    if (seen_holds != exp_holds) begin
      errors++;
      $display("FAIL R10: hold windows actual=%0d expected=%0d", seen_holds, exp_holds);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule